// File: doc/BRIEF.md
# Port Token-Bucket Rate Limiter

This block caps the output rate of several transmit ports by keeping a debt counter, the bucket level, for each port. Every data beat sent on a port is one 8-byte word and adds that port's word cost to its level. The first beat of a packet also adds the packet cost, scaled by 256, to pay for framing overhead that the word count leaves out. That overhead is 24 bytes of gap, preamble and CRC. The level drains by a fixed refill amount on every clock and stops at zero. It saturates at its all-ones value rather than wrapping.

Each port has its own packet cost, word cost and burst limit, loaded through one write strobe that carries a port number. A port's send-allowed flag drops while its level is above the limit scaled by 256. When the flag is low, the upstream scheduler should not start a new packet on that port. A packet that has already begun keeps its flag high until its last beat, so a packet is never cut in half. A word cost of zero makes the port limit packets per second only.

Top module: `rl_port_limiter`

## Requirements
- R1: After a synchronous reset every bucket level, packet cost, word cost and limit is zero, no packet is open, and every send_ok bit is 1.
- R2: A cycle with cfg_we high loads cfg_pkt_cost, cfg_word_cost and cfg_limit into the port named by cfg_port. The new values take effect from the next clock. Other ports keep their settings.
- R3: Each cycle with tx_valid high adds the selected port's word cost to that port's level.
- R4: A tx_valid beat with tx_sop high also adds the port's packet cost multiplied by 256.
- R5: On every clock each level first drops by REFILL, with a floor of 0, and then the charges of that clock are added.
- R6: With no packet open, send_ok[p] is 1 when level <= limit*256 and 0 when level > limit*256. A level exactly equal to limit*256 still allows sending.
- R7: After a beat with tx_sop=1 and tx_eop=0 on port p, send_ok[p] stays 1 until the clock after a beat with tx_eop=1 on port p.
- R8: A level that would exceed 2^LVL_W-1 holds at 2^LVL_W-1 instead of wrapping, where LVL_W = LIM_W+8.
- R9: With a word cost of 0 only packet starts raise the level, so the port is limited in packets per second.
- R10: A beat charges only the port named by tx_port. The levels and flags of all other ports follow their own drain only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PORT_W | Port whose settings are written |
| cfg_pkt_cost | input | PKT_W | Per-packet cost, in units of 256 tokens |
| cfg_word_cost | input | WORD_W | Per-word cost in tokens |
| cfg_limit | input | LIM_W | Burst limit, in units of 256 tokens |
| tx_valid | input | 1 | One 8-byte data word is sent this cycle |
| tx_port | input | PORT_W | Port of the current beat |
| tx_sop | input | 1 | Beat is the first word of a packet |
| tx_eop | input | 1 | Beat is the last word of a packet |
| send_ok | output | NUM_PORTS | Per-port send-allowed flag |

## Verification
The bench runs a model of every bucket in parallel with the design and compares all send_ok bits after every clock. Any error in the charge sum, the scaling by 256, the ordering of drain and charge, or the port decode therefore shows up as a flag that flips one or more cycles early or late. A level equal to limit*256 is targeted on its own, because a strict comparison written the wrong way would block one cycle too long. Multi-beat packets pushed far past the limit test the mid-packet hold: a design that gates every beat would drop the flag inside the packet. Repeated maximum-cost packets test saturation, since a wrapping counter would come back almost empty and allow sending at once instead of draining for dozens of cycles.

// File: rtl/rl_pkg.sv
package rl_pkg;

    // One beat as seen by a single bucket after port decode
    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
    } beat_t;

    // Scale applied to packet cost and limit relative to word tokens
    localparam int unsigned COARSE_SHIFT = 8;

    // Subtract with a floor at zero
    function automatic logic [31:0] sat_sub(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : 32'd0;
    endfunction

    // Add with a ceiling at max_v
    function automatic logic [31:0] sat_add(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] max_v);
        logic [32:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return (sum > {1'b0, max_v}) ? max_v : sum[31:0];
    endfunction

endpackage

// File: rtl/rl_cfg_bank.sv
module rl_cfg_bank #(
    parameter int NUM_PORTS = 4,
    parameter int PKT_W     = 10,
    parameter int WORD_W    = 12,
    parameter int LIM_W     = 12,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [PORT_W-1:0]                 wport,
    input  logic [PKT_W-1:0]                  wpkt,
    input  logic [WORD_W-1:0]                 wword,
    input  logic [LIM_W-1:0]                  wlim,
    output logic [NUM_PORTS-1:0][PKT_W-1:0]   pkt_cost,
    output logic [NUM_PORTS-1:0][WORD_W-1:0]  word_cost,
    output logic [NUM_PORTS-1:0][LIM_W-1:0]   limit
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = we && (wport == PORT_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                pkt_cost[p]  <= '0;
                word_cost[p] <= '0;
                limit[p]     <= '0;
            end else if (hit) begin
                pkt_cost[p]  <= wpkt;
                word_cost[p] <= wword;
                limit[p]     <= wlim;
            end
        end

        AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
            (we && wport == PORT_W'(p)) |=> (limit[p] == $past(wlim) && word_cost[p] == $past(wword)
                                             && pkt_cost[p] == $past(wpkt))); // R2
        AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(we && wport == PORT_W'(p)) |=> ($stable(limit[p]) && $stable(word_cost[p])
                                              && $stable(pkt_cost[p]))); // R2
    end

endmodule

// File: rtl/rl_bucket.sv
module rl_bucket
    import rl_pkg::*;
#(
    parameter int PKT_W    = 10,
    parameter int WORD_W   = 12,
    parameter int LIM_W    = 12,
    parameter int REFILL   = 3,
    localparam int LVL_W   = LIM_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             beat,
    input  logic [PKT_W-1:0]  pkt_cost,
    input  logic [WORD_W-1:0] word_cost,
    input  logic [LIM_W-1:0]  limit,
    output logic [LVL_W-1:0]  level,
    output logic              send_ok
);

    localparam logic [31:0] LVL_MAX = (32'd1 << LVL_W) - 32'd1;
    localparam logic [31:0] REFILL32 = 32'(REFILL);

    logic [31:0] charge;
    logic [31:0] drained;
    logic [31:0] next_lvl;
    logic [LVL_W-1:0] thresh;
    logic in_pkt;

    always_comb begin
        charge = 32'd0;
        if (beat.valid) begin
            charge = 32'(word_cost);
            if (beat.sop)
                charge = charge + (32'(pkt_cost) << COARSE_SHIFT);
        end
        drained  = sat_sub(32'(level), REFILL32);
        next_lvl = sat_add(drained, charge, LVL_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= '0;
            in_pkt <= 1'b0;
        end else begin
            level <= LVL_W'(next_lvl);
            if (beat.valid) begin
                if (beat.eop)
                    in_pkt <= 1'b0;
                else if (beat.sop)
                    in_pkt <= 1'b1;
            end
        end
    end

    assign thresh  = {limit, 8'h00};
    assign send_ok = in_pkt || (level <= thresh);

    AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (rst)
        !beat.valid |=> (level <= $past(level))); // R5
    AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!beat.valid && 32'(level) <= REFILL32) |=> (level == '0)); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && 32'(word_cost) >= REFILL32) |=> (level >= $past(level))); // R8
    AST_MIDPKT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && beat.sop && !beat.eop) |=> send_ok); // R7

endmodule

// File: rtl/rl_port_limiter.sv
module rl_port_limiter
    import rl_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PKT_W     = 10,
    parameter int WORD_W    = 12,
    parameter int LIM_W     = 12,
    parameter int REFILL    = 3,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int LVL_W    = LIM_W + 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [PORT_W-1:0]    cfg_port,
    input  logic [PKT_W-1:0]     cfg_pkt_cost,
    input  logic [WORD_W-1:0]    cfg_word_cost,
    input  logic [LIM_W-1:0]     cfg_limit,
    input  logic                 tx_valid,
    input  logic [PORT_W-1:0]    tx_port,
    input  logic                 tx_sop,
    input  logic                 tx_eop,
    output logic [NUM_PORTS-1:0] send_ok
);

    logic [NUM_PORTS-1:0][PKT_W-1:0]  pkt_cost;
    logic [NUM_PORTS-1:0][WORD_W-1:0] word_cost;
    logic [NUM_PORTS-1:0][LIM_W-1:0]  limit;
    logic [NUM_PORTS-1:0][LVL_W-1:0]  level;

    rl_cfg_bank #(
        .NUM_PORTS (NUM_PORTS),
        .PKT_W     (PKT_W),
        .WORD_W    (WORD_W),
        .LIM_W     (LIM_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wport     (cfg_port),
        .wpkt      (cfg_pkt_cost),
        .wword     (cfg_word_cost),
        .wlim      (cfg_limit),
        .pkt_cost  (pkt_cost),
        .word_cost (word_cost),
        .limit     (limit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bkt
        beat_t bt;
        always_comb begin
            bt.valid = tx_valid && (tx_port == PORT_W'(p));
            bt.sop   = tx_sop;
            bt.eop   = tx_eop;
        end

        rl_bucket #(
            .PKT_W   (PKT_W),
            .WORD_W  (WORD_W),
            .LIM_W   (LIM_W),
            .REFILL  (REFILL)
        ) u_bkt (
            .clk       (clk),
            .rst       (rst),
            .beat      (bt),
            .pkt_cost  (pkt_cost[p]),
            .word_cost (word_cost[p]),
            .limit     (limit[p]),
            .level     (level[p]),
            .send_ok   (send_ok[p])
        );

        AST_OTHER_PORT: assert property (@(posedge clk) disable iff (rst)
            !(tx_valid && tx_port == PORT_W'(p)) |=> (level[p] <= $past(level[p]))); // R10
    end

endmodule

// File: tb/rl_port_limiter_tb.sv
`timescale 1ns/1ps
module rl_port_limiter_tb;

    localparam int NP = 4;
    localparam int PKT_W = 10;
    localparam int WORD_W = 12;
    localparam int LIM_W = 12;
    localparam int REFILL = 3;
    localparam int PW = 2;
    localparam longint LMAX = (64'd1 << (LIM_W + 8)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [PW-1:0] cfg_port = '0;
    logic [PKT_W-1:0] cfg_pkt_cost = '0;
    logic [WORD_W-1:0] cfg_word_cost = '0;
    logic [LIM_W-1:0] cfg_limit = '0;
    logic tx_valid = 1'b0;
    logic [PW-1:0] tx_port = '0;
    logic tx_sop = 1'b0;
    logic tx_eop = 1'b0;
    logic [NP-1:0] send_ok;

    always #2 clk = ~clk;

    rl_port_limiter #(.NUM_PORTS(NP), .PKT_W(PKT_W), .WORD_W(WORD_W),
                      .LIM_W(LIM_W), .REFILL(REFILL)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_pkt_cost(cfg_pkt_cost), .cfg_word_cost(cfg_word_cost), .cfg_limit(cfg_limit),
        .tx_valid(tx_valid), .tx_port(tx_port), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .send_ok(send_ok));

    int checks = 0;
    int fails = 0;
    bit done = 0;

    longint m_lvl [NP];
    longint m_pc [NP];
    longint m_wc [NP];
    longint m_lim [NP];
    bit     m_in [NP];

    // Row: we, cport, pkt, word, lim, valid, tport, sop, eop, requirement
    localparam int NV = 14;
    localparam int VEC [NV][10] = '{
        '{1, 0, 2, 40, 1, 0, 0, 0, 0, 2},   // R2 port 0 setup
        '{1, 1, 1,  0, 0, 0, 0, 0, 0, 2},   // R2 port 1 packets only
        '{1, 3, 1,  3, 1, 0, 0, 0, 0, 2},   // R2 port 3 boundary setup
        '{0, 0, 0,  0, 0, 1, 0, 1, 0, 4},   // R4 start on port 0
        '{0, 0, 0,  0, 0, 1, 0, 0, 0, 7},   // R7 mid packet
        '{0, 0, 0,  0, 0, 1, 0, 0, 0, 7},   // R7 mid packet
        '{0, 0, 0,  0, 0, 1, 0, 0, 1, 3},   // R3 last word
        '{0, 0, 0,  0, 0, 0, 0, 0, 0, 6},   // R6 above limit
        '{0, 0, 0,  0, 0, 1, 1, 1, 1, 9},   // R9 one-beat packet
        '{0, 0, 0,  0, 0, 1, 1, 0, 0, 9},   // R9 free word
        '{0, 0, 0,  0, 0, 1, 2, 1, 1, 10},  // R10 zero-cost port
        '{0, 0, 0,  0, 0, 1, 3, 1, 1, 6},   // R6 boundary charge
        '{0, 0, 0,  0, 0, 0, 0, 0, 0, 6},   // R6 level equals threshold
        '{0, 0, 0,  0, 0, 0, 0, 0, 0, 5}    // R5 drain
    };

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_lvl[p] = 0; m_pc[p] = 0; m_wc[p] = 0; m_lim[p] = 0; m_in[p] = 0;
        end
    endtask

    task automatic model_edge(input bit r, input bit we, input int cp, input int pc,
                              input int wc, input int lim, input bit v, input int tp,
                              input bit sop, input bit eop);
        if (r) begin
            model_reset();
            return;
        end
        for (int p = 0; p < NP; p++) begin
            longint ch;
            longint nl;
            ch = 0;
            if (v && tp == p) begin
                ch = m_wc[p] + (sop ? m_pc[p] * 256 : 0);
                if (eop) m_in[p] = 0;
                else if (sop) m_in[p] = 1;
            end
            nl = (m_lvl[p] > REFILL) ? m_lvl[p] - REFILL : 0;
            nl = nl + ch;
            if (nl > LMAX) nl = LMAX;
            m_lvl[p] = nl;
        end
        if (we) begin
            m_pc[cp] = pc; m_wc[cp] = wc; m_lim[cp] = lim;
        end
    endtask

    task automatic check_all(input string tag);
        for (int p = 0; p < NP; p++) begin
            bit exp;
            exp = m_in[p] || (m_lvl[p] <= m_lim[p] * 256);
            checks++;
            if (send_ok[p] !== exp) begin
                fails++;
                $display("FAIL %s port %0d send_ok got %b expected %b", tag, p, send_ok[p], exp);
            end
        end
    endtask

    task automatic step(input bit r, input bit we, input int cp, input int pc, input int wc,
                        input int lim, input bit v, input int tp, input bit sop, input bit eop,
                        input string tag);
        @(negedge clk);
        rst = r; cfg_we = we; cfg_port = PW'(cp); cfg_pkt_cost = PKT_W'(pc);
        cfg_word_cost = WORD_W'(wc); cfg_limit = LIM_W'(lim);
        tx_valid = v; tx_port = PW'(tp); tx_sop = sop; tx_eop = eop;
        @(posedge clk);
        #1;
        model_edge(r, we, cp, pc, wc, lim, v, tp, sop, eop);
        check_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state, all flags high
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

        for (int i = 0; i < NV; i++)
            step(0, VEC[i][0] != 0, VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                 VEC[i][5] != 0, VEC[i][6], VEC[i][7] != 0, VEC[i][8] != 0,
                 $sformatf("R%0d", VEC[i][9]));

        // R5: long drain, flags rise in the cycle the model predicts
        idle(200, "R5");

        // R7: long packet far over limit stays allowed until its end
        step(0, 1, 0, 8, 500, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R7");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R7");
        idle(4, "R6");

        // R9: repeated packet starts on a zero word-cost port
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1, "R9");
        idle(3, "R9");

        // R8: saturation on port 2 followed by a drain near the top
        step(0, 1, 2, 1023, 4095, 4095, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 2, 1, 1, "R8");
        idle(100, "R8");

        // R10: traffic on port 3 only
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 1, 3, 1, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 1, 3, 0, 1, "R10");
        idle(400, "R5");

        // R1: reset in the middle of activity
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, "R4");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, "R1");
        checks++;
        if (send_ok !== 4'hF) begin
            fails++;
            $display("FAIL R1 send_ok after reset got %b expected 1111", send_ok);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule